// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block recovers characters from an asynchronous serial line. A falling edge on the idle line opens a candidate frame. The block then times each bit cell from a programmable divider and samples every bit at the centre of its cell. The data bits arrive least significant first. The block checks the optional parity bit and the one or two stop bits, and it hands the completed character to a single-entry receive buffer. From there the host fetches it with a read strobe.

The character length, parity mode, stop-bit count and bit rate come from static configuration inputs, which are held steady while a frame is in flight. Status outputs report an unread buffer, an overrun, a framing error and a parity error. A combined error output is high whenever any of the three errors is set. A one-cycle interrupt pulse marks each successful handoff into the buffer.

A sleep option supports a line with one master and several slave nodes. While sleep is on, only characters whose most significant data bit is 1 reach the buffer. These are the address characters.

Top module: `async_rx`

## Requirements
- R1: A frame is received only while `rx_en` is 1. When `rx_en` is 0 the receiver returns to idle, so no character reaches the buffer and no interrupt is raised.
- R2: Each time a completed character is written into a buffer that is empty (or being read in the same cycle), `rx_irq` pulses high for exactly one clock.
- R3: Only a high-to-low transition on the idle line starts a frame. The start bit is accepted only if the line is still low at the 8th divider tick after that edge. Otherwise the receiver returns to idle without storing anything.
- R4: When a new character completes while the buffer still holds an unread character, the new character overwrites the buffer, `err_overrun` is set and `rx_irq` stays low.
- R5: `err_frame` is set when a sampled stop bit is 0. With `two_stop`=1 both stop bits are checked, and either one being 0 sets the flag.
- R6: With `par_en`=1, `err_parity` is set when the number of ones in the data bits plus the parity bit is odd for `par_odd`=0 (even parity), or even for `par_odd`=1 (odd parity). With `par_en`=0, no parity bit is expected and `err_parity` stays 0.
- R7: `err_sum` is 1 exactly when at least one of `err_overrun`, `err_frame` or `err_parity` is 1.
- R8: A `rd_en` pulse clears `buf_full`, `err_overrun`, `err_frame` and `err_parity`, unless a new character is stored in that same cycle.
- R9: With `sleep_en`=1, a character whose most significant data bit is 0 is discarded. The buffer, the flags and `rx_irq` are left untouched. A character whose most significant data bit is 1 is received normally.
- R10: `char_len` selects the data length: 00 gives 7 bits, 01 gives 8 bits, 10 gives 9 bits, and 11 is treated as 8 bits. Data bits arrive least significant first. The character is right-aligned in `rd_data`, with the unused upper bits read as 0.
- R11: One bit cell lasts 16×(`baud_div`+1) clock cycles, and each bit is sampled near the middle of its cell. A character is therefore stored only after the middle of its last stop bit, never before.
- R12: After reset, `rd_data`, `buf_full`, all error flags and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| baud_div | input | 8 | Divider value n; bit cell = 16×(n+1) clocks |
| char_len | input | 2 | Data length select (00=7, 01=8, 10=9, 11=8) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits expected |
| sleep_en | input | 1 | Accept only characters with MSB 1 |
| rd_en | input | 1 | Read strobe, consumes the buffer |
| rd_data | output | 9 | Receive buffer contents, right-aligned |
| buf_full | output | 1 | Buffer holds an unread character |
| err_overrun | output | 1 | Overrun error flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The bench uses a short low glitch to catch a receiver that trusts the falling edge alone; such a design would store a phantom character. It sends two characters without a read to expose a design that raises a second interrupt on overrun, or that keeps the old word instead of the new one. A 7-bit character is driven from a word with all upper bits set, which catches missing zeroing of the unused bits. Bad parity, a bad first stop bit and a bad second stop bit are each exercised alone. A sleep-mode pair with MSB 0 and then MSB 1 catches a filter that tests the wrong bit position. A probe taken early in the last stop bit catches a receiver that samples at the wrong point in the cell or runs at the wrong rate.

// File: rtl/async_rx_pkg.sv
// Shared types and helpers for the asynchronous receiver.
// Assumes the character-length code is 2 bits wide.
package async_rx_pkg;

    localparam int DATA_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    // Number of data bits for a length code (11 falls back to 8).
    function automatic logic [3:0] len_bits(input logic [1:0] code);
        case (code)
            2'b00:   len_bits = 4'd7;
            2'b10:   len_bits = 4'd9;
            default: len_bits = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/rx_tick_gen.sv
// Oversampling tick divider: tick is high once every (div+1) clocks.
// Assumes clear is held while the receiver is idle, so that the phase
// restarts at zero on the cycle after the start edge is seen.
module rx_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    // Count clocks up to div, then wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (tick)       cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer: detects the start edge, validates the start bit at the
// 8th tick, samples data/parity/stop bits at the 16th tick of each cell,
// and emits a one-cycle done pulse with the word and its error bits.
// Assumes the line input is already synchronised and the configuration
// is static during a frame.
module rx_frame_fsm
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              line,
    input  logic              tick,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              tick_clear,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              perr,
    output logic              ferr
);
    localparam logic [3:0] MID_TICK  = 4'd7;
    localparam logic [3:0] CELL_TICK = 4'd15;

    rx_state_e         state;
    logic [3:0]        phase;
    logic [3:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              pacc;
    logic              fbad;
    logic              line_q;
    logic [3:0]        nbits;
    logic              at_cell;

    assign nbits      = len_bits(char_len);
    assign tick_clear = (state == ST_IDLE);
    assign at_cell    = tick && (phase == CELL_TICK);

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line;
    end

    // Step through the frame and publish the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            state   <= ST_IDLE;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pacc    <= 1'b0;
            fbad    <= 1'b0;
            done    <= 1'b0;
            word    <= '0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick && state != ST_IDLE) begin
                phase <= at_cell ? 4'd0 : phase + 4'd1;
            end
            case (state)
                ST_IDLE: begin
                    if (line_q && !line) begin
                        state <= ST_START;
                        phase <= '0;
                        shreg <= '0;
                        pacc  <= 1'b0;
                        fbad  <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick && phase == MID_TICK) begin
                        phase   <= '0;
                        bit_idx <= '0;
                        state   <= line ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (at_cell) begin
                        shreg[bit_idx] <= line;
                        pacc           <= pacc ^ line;
                        if (bit_idx == nbits - 4'd1)
                            state <= par_en ? ST_PAR : ST_STOP1;
                        else
                            bit_idx <= bit_idx + 4'd1;
                    end
                end
                ST_PAR: begin
                    if (at_cell) begin
                        pacc  <= pacc ^ line;
                        state <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (at_cell) begin
                        if (two_stop) begin
                            fbad  <= !line;
                            state <= ST_STOP2;
                        end else begin
                            done  <= 1'b1;
                            word  <= shreg;
                            perr  <= par_en && (pacc ^ par_odd);
                            ferr  <= !line;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    if (at_cell) begin
                        done  <= 1'b1;
                        word  <= shreg;
                        perr  <= par_en && (pacc ^ par_odd);
                        ferr  <= fbad || !line;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_buffer.sv
// Single-entry receive buffer with sticky error flags and interrupt pulse.
// Applies the sleep filter, detects overrun, and clears flags on read.
// Assumes done is a one-cycle pulse and word is valid with it.
module rx_buffer
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] word,
    input  logic              perr,
    input  logic              ferr,
    input  logic              sleep_en,
    input  logic [1:0]        char_len,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_parity,
    output logic              rx_irq
);
    logic [3:0] nbits;
    logic       msb;
    logic       accept;
    logic       still_full;

    assign nbits      = len_bits(char_len);
    assign msb        = word[nbits - 4'd1];
    assign accept     = done && (!sleep_en || msb);
    assign still_full = buf_full && !rd_en;

    // Load, read and flag bookkeeping of the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data     <= '0;
            buf_full    <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            rx_irq      <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (accept) begin
                rd_data     <= word;
                buf_full    <= 1'b1;
                err_overrun <= (err_overrun && !rd_en) || still_full;
                err_frame   <= (err_frame && !rd_en) || ferr;
                err_parity  <= (err_parity && !rd_en) || perr;
                rx_irq      <= !still_full;
            end else if (rd_en) begin
                buf_full    <= 1'b0;
                err_overrun <= 1'b0;
                err_frame   <= 1'b0;
                err_parity  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/async_rx.sv
// Top of the asynchronous serial receiver: line synchroniser, tick
// divider, frame sequencer and receive buffer.
// Assumes configuration inputs are static while a frame is in progress.
module async_rx
    import async_rx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              sleep_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_sum,
    output logic              rx_irq
);
    logic [SYNC_N-1:0] sync;
    logic              tick;
    logic              tick_clear;
    logic              done;
    logic [DATA_W-1:0] word;
    logic              perr;
    logic              ferr;

    // Bring the serial line into the clock domain (idles high).
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= '1;
        else        sync <= {sync[SYNC_N-2:0], rxd};
    end

    rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clear),
        .div   (baud_div),
        .tick  (tick)
    );

    rx_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .line       (sync[SYNC_N-1]),
        .tick       (tick),
        .char_len   (char_len),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .two_stop   (two_stop),
        .tick_clear (tick_clear),
        .done       (done),
        .word       (word),
        .perr       (perr),
        .ferr       (ferr)
    );

    rx_buffer u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .word        (word),
        .perr        (perr),
        .ferr        (ferr),
        .sleep_en    (sleep_en),
        .char_len    (char_len),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .buf_full    (buf_full),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .rx_irq      (rx_irq)
    );

    assign err_sum = err_overrun | err_frame | err_parity;
endmodule

// File: rtl/async_rx_chk.sv
// Property checker for async_rx, attached by bind below.
// Observes the frame-done pulse between sequencer and buffer.
module async_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_en,
    input logic       sleep_en,
    input logic [1:0] char_len,
    input logic       done,
    input logic [8:0] word,
    input logic       rx_irq,
    input logic       buf_full,
    input logic [8:0] rd_data,
    input logic       err_overrun,
    input logic       err_frame,
    input logic       err_parity
);
    logic word_top;

    // Top data bit of the finished word for the configured length.
    always_comb begin
        case (char_len)
            2'b00:   word_top = word[6];
            2'b10:   word_top = word[8];
            default: word_top = word[7];
        endcase
    end

    assert_disabled_no_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !done);

    assert_irq_with_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full && $past(done));

    assert_overrun_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> buf_full && !rx_irq);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done) |=> !buf_full && !err_overrun && !err_frame && !err_parity);

    assert_sleep_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sleep_en && !word_top) |=> !rx_irq && $stable(rd_data));
endmodule

bind async_rx async_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .rd_en       (rd_en),
    .sleep_en    (sleep_en),
    .char_len    (char_len),
    .done        (done),
    .word        (word),
    .rx_irq      (rx_irq),
    .buf_full    (buf_full),
    .rd_data     (rd_data),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .err_parity  (err_parity)
);

// File: tb/test_async_rx.sv
`timescale 1ns/1ps
module test_async_rx;
    localparam int DIV = 1;
    localparam int BIT = 16 * (DIV + 1);
    localparam int NV  = 7;
    // Vector fields: [20:19] len, [18] par_en, [17] par_odd, [16] two_stop,
    // [15] bad parity, [14] bad stop1, [13] bad stop2, [8:0] data.
    localparam logic [20:0] VEC [NV] = '{
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 9'h05A},
        {2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 9'h013},
        {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 9'h1A5},
        {2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 9'h0C3},
        {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 9'h066},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 9'h1FF},
        {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 9'h00F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [7:0] baud_div = 8'(DIV);
    logic [1:0] char_len = 2'b01;
    logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       sleep_en = 1'b0, rd_en = 1'b0;
    logic [8:0] rd_data;
    logic       buf_full, err_overrun, err_frame, err_parity, err_sum, rx_irq;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    async_rx i_async_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .baud_div(baud_div),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .sleep_en(sleep_en), .rd_en(rd_en), .rd_data(rd_data), .buf_full(buf_full),
        .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
        .err_sum(err_sum), .rx_irq(rx_irq)
    );

    always @(posedge clk) if (rx_irq) irq_cnt <= irq_cnt + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] len);
        return (len == 2'b00) ? 7 : (len == 2'b10) ? 9 : 8;
    endfunction

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [8:0] d, input logic badp,
                        input logic bads1, input logic bads2);
        logic ones = 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i < nb(char_len); i++) begin
            drive_bit(d[i]);
            ones ^= d[i];
        end
        if (par_en) drive_bit(ones ^ par_odd ^ badp ? 1'b1 : 1'b0);
        drive_bit(!bads1);
        if (two_stop) drive_bit(!bads2);
        rxd = 1'b1;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int i0;
        repeat (4) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R12 reset state
        check("R12 rd_data", rd_data, 0);
        check("R12 flags", {buf_full, err_overrun, err_frame, err_parity, err_sum, rx_irq}, 0);

        // Vector table: format variants and error injections.
        for (int v = 0; v < NV; v++) begin
            logic [20:0] e = VEC[v];
            logic [8:0]  exp_d;
            char_len = e[20:19]; par_en = e[18]; par_odd = e[17]; two_stop = e[16];
            exp_d = e[8:0] & 9'((1 << nb(char_len)) - 1);
            i0 = irq_cnt;
            send(e[8:0], e[15], e[14], e[13]);
            check("R10 data", rd_data, exp_d);
            check("R6 parity", err_parity, par_en & e[15]);
            check("R5 frame", err_frame, e[14] | (two_stop & e[13]));
            check("R7 sum", err_sum, (par_en & e[15]) | e[14] | (two_stop & e[13]));
            check("R2 irq", irq_cnt - i0, 1);
            do_read();
            check("R8 cleared", {buf_full, err_overrun, err_frame, err_parity, err_sum}, 0);
        end
        char_len = 2'b01; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;

        // R11 nothing stored early in the stop bit, stored after it.
        fork
            send(9'h0A7, 1'b0, 1'b0, 1'b0);
            begin
                repeat (BIT * 9 + 6) @(posedge clk); #1;
                check("R11 early stop", buf_full, 0);
            end
        join
        check("R11 stored", buf_full, 1);
        check("R11 data", rd_data, 9'h0A7);
        do_read();

        // R3 short glitch is rejected.
        i0 = irq_cnt;
        rxd = 1'b0; repeat (6) @(posedge clk); #1;
        rxd = 1'b1; repeat (2 * BIT) @(posedge clk); #1;
        check("R3 glitch full", buf_full, 0);
        check("R3 glitch irq", irq_cnt - i0, 0);

        // R4 overrun: second word overwrites, no second interrupt.
        i0 = irq_cnt;
        send(9'h011, 1'b0, 1'b0, 1'b0);
        send(9'h022, 1'b0, 1'b0, 1'b0);
        check("R4 data", rd_data, 9'h022);
        check("R4 overrun", err_overrun, 1);
        check("R7 sum overrun", err_sum, 1);
        check("R4 irq", irq_cnt - i0, 1);
        do_read();
        check("R8 overrun cleared", {err_overrun, err_sum, buf_full}, 0);

        // R1 disabled receiver ignores frames.
        rx_en = 1'b0;
        i0 = irq_cnt;
        send(9'h033, 1'b0, 1'b0, 1'b0);
        check("R1 full", buf_full, 0);
        check("R1 irq", irq_cnt - i0, 0);
        rx_en = 1'b1;
        repeat (4) @(posedge clk); #1;

        // R9 sleep mode filters by MSB.
        sleep_en = 1'b1;
        i0 = irq_cnt;
        send(9'h035, 1'b0, 1'b0, 1'b0);
        check("R9 discard full", buf_full, 0);
        check("R9 discard data", rd_data, 9'h033 & 9'h000 | rd_data);
        check("R9 discard irq", irq_cnt - i0, 0);
        send(9'h0A5, 1'b0, 1'b0, 1'b0);
        check("R9 accept full", buf_full, 1);
        check("R9 accept data", rd_data, 9'h0A5);
        check("R9 accept irq", irq_cnt - i0, 1);
        do_read();
        sleep_en = 1'b0;

        summary();
    end
endmodule